// File: doc/BRIEF.md
# Branch Redirect and Flush Controller

This block steers instruction fetch for a five-stage in-order pipeline that settles branches while they sit in decode. A dedicated target adder, kept apart from the execute-stage ALU, turns the decode-stage PC and a signed word offset into a branch target. In the same cycle the controller tells the fetch unit whether the next PC is the sequential address or that target. It also says whether the fetch/decode register must be replaced with a no-op.

A parameter picks one of two fixed policies. Under predict-not-taken, fetch runs on sequentially past every branch. A taken branch costs one cycle: the redirect selects the target, and the instruction fetched behind the branch is squashed. Under the delay-slot policy, the instruction right behind the branch always completes. The redirect to the target is still issued when the branch resolves, so it takes effect after that slot instruction, and no flush is ever raised.

A saturating counter records every squashed cycle, so a performance test can compare cycle counts against the ideal. A stall from the interlock unit takes precedence over the redirect decision. A branch held in decode is only resolved in the first cycle in which decode is free to advance.

The control is a three-state machine, with states named:
- `ST_RUN`: decode holds an ordinary instruction.
- `ST_BUBBLE`: decode holds the no-op left by a squash.
- `ST_SLOT`: decode holds a delay-slot instruction.

Its transitions are:
- `ST_RUN` to `ST_BUBBLE` when a taken branch resolves under predict-not-taken.
- `ST_RUN` to `ST_SLOT` when any branch resolves under the delay-slot policy.
- `ST_BUBBLE` to `ST_RUN` when the stall is low.
- `ST_SLOT` to `ST_RUN` when the stall is low.
- Every other case holds the current state.

Top module: `branch_redirect_ctrl`

## Requirements
- R1: After reset the controller is in `ST_RUN` with redirect low, flush low and the penalty count zero.
- R2: The target output always equals the decode PC plus 4 plus the sign-extended word offset shifted left by two bits, modulo 2^XLEN, in the same cycle.
- R3: Under predict-not-taken, a branch whose condition is false raises neither redirect nor flush and leaves the penalty count unchanged.
- R4: Under predict-not-taken, a taken branch raises redirect and flush in the cycle it resolves, and the penalty count is one higher from the next cycle on.
- R5: Under predict-not-taken, a branch flag in the cycle after a squash (decode holds the no-op) is ignored: no redirect, no flush, no count.
- R6: Under the delay-slot policy, a taken branch raises redirect in the cycle it resolves, flush stays low at all times, and the penalty count stays zero.
- R7: Under the delay-slot policy, an untaken branch raises no redirect.
- R8: Under the delay-slot policy, a branch flag in the cycle after any resolved branch (the slot instruction is in decode) is ignored; under predict-not-taken, a branch after an untaken branch resolves normally.
- R9: While the stall input is high, redirect and flush stay low and the state holds; a branch held through the stall resolves in the first cycle the stall is low.
- R10: The penalty count saturates at 2^CNT_W-1 and does not wrap.
- R11: Under predict-not-taken, a loop of n iterations whose closing branch is taken n-1 times and falls through on exit yields a penalty count of exactly n-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_br_i | input | 1 | Decode stage holds a conditional branch |
| dec_cond_i | input | 1 | Branch condition result, 1 means taken |
| dec_stall_i | input | 1 | Interlock stall; decode does not advance |
| dec_pc_i | input | XLEN | PC of the instruction in decode |
| dec_off_i | input | OFF_W | Signed branch offset in words |
| redirect_o | output | 1 | Next-PC select: 1 picks the target, 0 the sequential PC |
| target_o | output | XLEN | Branch target from the decode adder |
| flush_fd_o | output | 1 | Turn the fetch/decode register into a no-op |
| penalty_cnt_o | output | CNT_W | Saturating count of squashed cycles |

## Verification
The hardest situation to reach is a branch flag that arrives while decode holds something the controller must not resolve. That happens either just after a squash or in a delay slot, and the distinction shows only by comparing the two policies on identical stimulus. The bench drives the same flag sequence into one instance of each policy. An untaken branch followed at once by another branch separates them: the second branch resolves under predict-not-taken but is ignored as a slot instruction under the delay-slot policy. A stall held across a pending taken branch, then released, shows that the decision is deferred rather than lost.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_BUBBLE = 2'd1,
        ST_SLOT   = 2'd2
    } brc_state_e;

    typedef enum logic {
        POL_NOT_TAKEN  = 1'b0,
        POL_DELAY_SLOT = 1'b1
    } brc_policy_e;

endpackage

// File: rtl/brc_tgt_adder.sv
module brc_tgt_adder #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [XLEN-1:0]  tgt_o
);
    localparam int EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] seq_pc;

    // sign-extend the word offset, then scale to bytes
    assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
    assign seq_pc  = pc_i + XLEN'(4);
    assign tgt_o   = seq_pc + (off_ext << 2);

    initial begin
        assert (OFF_W + 2 <= XLEN) else $error("offset field too wide for XLEN");
    end
endmodule

// File: rtl/brc_fsm.sv
module brc_fsm
    import brc_pkg::*;
#(
    parameter brc_policy_e POLICY = POL_NOT_TAKEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic br_i,
    input  logic cond_i,
    input  logic stall_i,
    output logic sel_o,
    output logic flush_o
);
    brc_state_e state_q, state_d;
    logic       resolve;
    logic       squash_en;

    // policy variant: only predict-not-taken may squash
    generate
        if (POLICY == POL_DELAY_SLOT) begin : g_slot
            assign squash_en = 1'b0;
        end else begin : g_pnt
            assign squash_en = 1'b1;
        end
    endgenerate

    assign resolve = br_i && !stall_i && (state_q == ST_RUN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (resolve) begin
                    if (POLICY == POL_DELAY_SLOT) state_d = ST_SLOT;
                    else if (cond_i)              state_d = ST_BUBBLE;
                end
            end
            ST_BUBBLE: if (!stall_i) state_d = ST_RUN;
            ST_SLOT:   if (!stall_i) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        sel_o   = 1'b0;
        flush_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                sel_o   = resolve && cond_i;
                flush_o = resolve && cond_i && squash_en;
            end
            ST_BUBBLE, ST_SLOT: begin
                sel_o   = 1'b0;
                flush_o = 1'b0;
            end
            default: begin
                sel_o   = 1'b0;
                flush_o = 1'b0;
            end
        endcase
    end

    p_flush_has_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> sel_o);
    p_no_back2back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o && !stall_i |=> !sel_o);
    p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !sel_o && !flush_o);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> state_q == ST_RUN);

    generate
        if (POLICY == POL_DELAY_SLOT) begin : g_chk_slot
            p_slot_no_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !flush_o);
            p_slot_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
                br_i && !stall_i && state_q == ST_RUN |=> !sel_o);
        end
    endgenerate
endmodule

// File: rtl/brc_pen_ctr.sv
module brc_pen_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
    end

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && cnt_o != CNT_MAX |=> cnt_o == $past(cnt_o) + 1'b1);
    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o == CNT_MAX |=> cnt_o == CNT_MAX);
    p_cnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/branch_redirect_ctrl.sv
module branch_redirect_ctrl
    import brc_pkg::*;
#(
    parameter int          XLEN   = 32,
    parameter int          OFF_W  = 16,
    parameter int          CNT_W  = 16,
    parameter brc_policy_e POLICY = POL_NOT_TAKEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_br_i,
    input  logic             dec_cond_i,
    input  logic             dec_stall_i,
    input  logic [XLEN-1:0]  dec_pc_i,
    input  logic [OFF_W-1:0] dec_off_i,
    output logic             redirect_o,
    output logic [XLEN-1:0]  target_o,
    output logic             flush_fd_o,
    output logic [CNT_W-1:0] penalty_cnt_o
);
    brc_tgt_adder #(.XLEN(XLEN), .OFF_W(OFF_W)) u_adder (
        .pc_i  (dec_pc_i),
        .off_i (dec_off_i),
        .tgt_o (target_o)
    );

    brc_fsm #(.POLICY(POLICY)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .br_i    (dec_br_i),
        .cond_i  (dec_cond_i),
        .stall_i (dec_stall_i),
        .sel_o   (redirect_o),
        .flush_o (flush_fd_o)
    );

    brc_pen_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (flush_fd_o),
        .cnt_o (penalty_cnt_o)
    );

    p_untaken_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_br_i && !dec_cond_i |-> !redirect_o && !flush_fd_o);
endmodule

// File: tb/test_branch_redirect_ctrl.sv
module test_branch_redirect_ctrl;
    import brc_pkg::*;

    localparam int XLEN = 32, OFF_W = 16, CNT_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic br = 1'b0, cond = 1'b0, stall = 1'b0;
    logic [XLEN-1:0]  pc = '0;
    logic [OFF_W-1:0] off = '0;
    logic sel_a, flush_a, sel_b, flush_b;
    logic [XLEN-1:0]  tgt_a, tgt_b;
    logic [CNT_W-1:0] cnt_a, cnt_b;
    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    branch_redirect_ctrl #(.XLEN(XLEN), .OFF_W(OFF_W), .CNT_W(CNT_W),
                           .POLICY(POL_NOT_TAKEN)) i_branch_redirect_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_br_i(br), .dec_cond_i(cond),
        .dec_stall_i(stall), .dec_pc_i(pc), .dec_off_i(off),
        .redirect_o(sel_a), .target_o(tgt_a), .flush_fd_o(flush_a),
        .penalty_cnt_o(cnt_a));

    branch_redirect_ctrl #(.XLEN(XLEN), .OFF_W(OFF_W), .CNT_W(CNT_W),
                           .POLICY(POL_DELAY_SLOT)) i_branch_redirect_ctrl_dly (
        .clk(clk), .rst_n(rst_n), .dec_br_i(br), .dec_cond_i(cond),
        .dec_stall_i(stall), .dec_pc_i(pc), .dec_off_i(off),
        .redirect_o(sel_b), .target_o(tgt_b), .flush_fd_o(flush_b),
        .penalty_cnt_o(cnt_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one decode cycle after the falling edge, settle, then return
    task automatic cyc(input logic b, input logic c, input logic s);
        @(negedge clk);
        br = b; cond = c; stall = s;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; br = 1'b0; cond = 1'b0; stall = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        cyc(0, 0, 0);
        chk("R1 sel pnt", 32'(sel_a), 32'd0);
        chk("R1 flush pnt", 32'(flush_a), 32'd0);
        chk("R1 cnt pnt", 32'(cnt_a), 32'd0);
        chk("R1 sel dly", 32'(sel_b), 32'd0);
        chk("R1 cnt dly", 32'(cnt_b), 32'd0);
    endtask

    task automatic t_target();
        logic [31:0] pcs  [4] = '{32'h0000_1000, 32'h0000_2000, 32'hFFFF_FFFC, 32'h0004_0000};
        logic [15:0] offs [4] = '{16'h0003, 16'hFFFF, 16'h0000, 16'h8000};
        logic [31:0] exps [4] = '{32'h0000_1010, 32'h0000_2000, 32'h0000_0000, 32'h0002_0004};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pc = pcs[i]; off = offs[i];
            #1;
            chk("R2 target pnt", tgt_a, exps[i]);
            chk("R2 target dly", tgt_b, exps[i]);
        end
    endtask

    task automatic t_untaken();
        do_reset();
        cyc(1, 0, 0);
        chk("R3 sel", 32'(sel_a), 32'd0);
        chk("R3 flush", 32'(flush_a), 32'd0);
        chk("R7 sel dly", 32'(sel_b), 32'd0);
        cyc(0, 0, 0);
        chk("R3 cnt", 32'(cnt_a), 32'd0);
    endtask

    task automatic t_taken();
        do_reset();
        cyc(1, 1, 0);
        chk("R4 sel", 32'(sel_a), 32'd1);
        chk("R4 flush", 32'(flush_a), 32'd1);
        chk("R6 sel dly", 32'(sel_b), 32'd1);
        chk("R6 flush dly", 32'(flush_b), 32'd0);
        cyc(1, 1, 0);
        chk("R4 cnt", 32'(cnt_a), 32'd1);
        chk("R5 sel in bubble", 32'(sel_a), 32'd0);
        chk("R5 flush in bubble", 32'(flush_a), 32'd0);
        chk("R8 sel in slot", 32'(sel_b), 32'd0);
        cyc(0, 0, 0);
        chk("R5 cnt unchanged", 32'(cnt_a), 32'd1);
        chk("R6 cnt dly", 32'(cnt_b), 32'd0);
    endtask

    task automatic t_slot_vs_seq();
        do_reset();
        cyc(1, 0, 0);
        cyc(1, 1, 0);
        chk("R8 pnt resolves", 32'(sel_a), 32'd1);
        chk("R8 pnt flush", 32'(flush_a), 32'd1);
        chk("R8 dly slot ignored", 32'(sel_b), 32'd0);
        cyc(0, 0, 0);
        cyc(1, 1, 0);
        chk("R8 dly resolves after slot", 32'(sel_b), 32'd1);
        cyc(0, 0, 0);
    endtask

    task automatic t_stall();
        do_reset();
        for (int i = 0; i < 2; i++) begin
            cyc(1, 1, 1);
            chk("R9 stall sel pnt", 32'(sel_a), 32'd0);
            chk("R9 stall flush pnt", 32'(flush_a), 32'd0);
            chk("R9 stall sel dly", 32'(sel_b), 32'd0);
        end
        cyc(1, 1, 0);
        chk("R9 release sel pnt", 32'(sel_a), 32'd1);
        chk("R9 release flush pnt", 32'(flush_a), 32'd1);
        chk("R9 release sel dly", 32'(sel_b), 32'd1);
        cyc(0, 0, 0);
        chk("R9 cnt", 32'(cnt_a), 32'd1);
    endtask

    task automatic t_loop();
        int n = 6;
        do_reset();
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 0);
            cyc(0, 0, 0);
            cyc(1, (i < n - 1), 0);
            cyc(0, 0, 0);
        end
        cyc(0, 0, 0);
        chk("R11 loop penalties", 32'(cnt_a), 32'(n - 1));
        chk("R11 loop dly no penalty", 32'(cnt_b), 32'd0);
    endtask

    task automatic t_sat();
        do_reset();
        for (int i = 0; i < 10; i++) begin
            cyc(1, 1, 0);
            cyc(0, 0, 0);
        end
        chk("R10 saturate", 32'(cnt_a), 32'd7);
        cyc(1, 1, 0);
        cyc(0, 0, 0);
        chk("R10 hold at max", 32'(cnt_a), 32'd7);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_target();
        t_untaken();
        t_taken();
        t_slot_vs_seq();
        t_stall();
        t_loop();
        t_sat();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule